// File: doc/BRIEF.md
# Dual Vector Logical Issue Arbiter

This block chooses which of two vector logical execution units takes each vector logical instruction that reaches issue. One unit is the full unit. The other is a secondary unit that a program may switch on. The secondary unit shares its operand and result paths with the floating-point multiply unit, so a multiply reservation on those paths blocks it.

The arbiter prefers the secondary unit and falls back to the full unit. When neither unit can take the instruction, it raises an issue hold. The instruction then waits until a unit frees. A granted unit stays reserved for the length of the vector operation plus the pipeline latency, and a down-counter inside the arbiter times that reservation.

A two-state machine sequences the work:
- `ST_READY` accepts a new request. It moves to `ST_HOLD` when the request finds no usable unit.
- `ST_HOLD` keeps the waiting instruction. It returns to `ST_READY` in the cycle that a usable unit is seen free, and that unit is granted.

Top module: `vla_issue_arb`

## Requirements
- R1: With `second_en` low, only `grant_full` is ever raised. A request that finds the full unit busy waits, even when the secondary unit is idle.
- R2: With `second_en` high, the secondary unit free and `fpm_conflict` low, a request is granted to the secondary unit.
- R3: When the secondary unit is busy and the full unit is free, a request is granted to the full unit.
- R4: When no unit can take a request, `issue_hold` is high from the cycle after the request until the cycle in which the grant appears. The waiting instruction keeps the vector length it was requested with. Requests presented while holding are ignored.
- R5: With `fpm_conflict` high, the secondary unit is treated as unavailable, so the request goes to the full unit or waits.
- R6: A granted unit shows its busy output from the cycle its grant is visible for exactly `vec_len + 2` cycles. `vec_len` ranges over 1 to 64.
- R7: A unit becomes grantable in the first cycle its busy output is low. An instruction that was waiting is granted to it in that cycle.
- R8: If both units are free in the same cycle while an instruction waits, the secondary unit wins when it is enabled and has no conflict. Otherwise the full unit wins.
- R9: Grants and hold are registered and appear one cycle after the deciding request or cycle. At most one grant is high at a time, and a grant lasts one cycle.
- R10: During and right after reset, no grant, no hold and no busy are shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | 1 | A vector logical instruction is at issue |
| vec_len | input | 7 | Element count of the requesting instruction, 1 to 64 |
| second_en | input | 1 | Program enable for the secondary logical unit |
| fpm_conflict | input | 1 | Floating-point multiply holds the shared paths |
| grant_full | output | 1 | Instruction issued to the full unit (one-cycle pulse) |
| grant_second | output | 1 | Instruction issued to the secondary unit (one-cycle pulse) |
| issue_hold | output | 1 | An instruction is waiting for a unit |
| busy_full | output | 1 | Full unit reserved |
| busy_second | output | 1 | Secondary unit reserved |

## Verification
Suppose the state register or a reservation counter is wrong. A mis-loaded or mis-decremented counter shows on the busy output as a reservation that ends early or late, and the next grant then moves by the same number of cycles. A state machine stuck in `ST_HOLD` keeps `issue_hold` high past the cycle a unit is seen free. A wrong preference shows up as the other grant pulse in the very cycle after the decision. Every such fault therefore reaches the ports within one cycle of the decision, or by the end of the reservation it disturbed.

// File: rtl/vla_pkg.sv
`timescale 1ns/1ps
package vla_pkg;
    localparam int NUM_UNITS   = 2;
    localparam int UNIT_FULL   = 0;
    localparam int UNIT_SECOND = 1;

    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_FULL   = 2'd1,
        PICK_SECOND = 2'd2
    } pick_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_HOLD  = 1'b1
    } arb_state_e;
endpackage

// File: rtl/vla_res_ctr.sv
`timescale 1ns/1ps
// Reservation timer for one logical unit: loads on grant, counts to zero.
module vla_res_ctr #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/vla_pick.sv
`timescale 1ns/1ps
// Preference order: secondary unit when usable, else full unit, else none.
module vla_pick
    import vla_pkg::*;
(
    input  logic  want,
    input  logic  full_free,
    input  logic  second_free,
    input  logic  second_en,
    input  logic  path_conflict,
    output pick_e pick
);
    logic second_usable;

    assign second_usable = second_en && second_free && !path_conflict;

    always_comb begin
        if (!want) begin
            pick = PICK_NONE;
        end else if (second_usable) begin
            pick = PICK_SECOND;
        end else if (full_free) begin
            pick = PICK_FULL;
        end else begin
            pick = PICK_NONE;
        end
    end
endmodule

// File: rtl/vla_issue_arb.sv
`timescale 1ns/1ps
module vla_issue_arb
    import vla_pkg::*;
#(
    parameter int VL_W     = 7,
    parameter int MAX_VL   = 64,
    parameter int PIPE_LAT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_req,
    input  logic [VL_W-1:0] vec_len,
    input  logic            second_en,
    input  logic            fpm_conflict,
    output logic            grant_full,
    output logic            grant_second,
    output logic            issue_hold,
    output logic            busy_full,
    output logic            busy_second
);
    localparam int CNT_W = $clog2(MAX_VL + PIPE_LAT + 1);

    arb_state_e          state_q, state_nx;
    logic [VL_W-1:0]     pend_vl_q;
    logic [VL_W-1:0]     eff_vl;
    logic                want;
    pick_e               pick;
    logic [NUM_UNITS-1:0] unit_load;
    logic [NUM_UNITS-1:0] unit_busy;
    logic [CNT_W-1:0]    load_val;
    logic                grant_full_q, grant_second_q, hold_q;

    // Request source: a waiting instruction takes precedence over the port.
    assign want   = (state_q == ST_HOLD) || issue_req;
    assign eff_vl = (state_q == ST_HOLD) ? pend_vl_q : vec_len;
    assign load_val = CNT_W'(eff_vl) + CNT_W'(PIPE_LAT);

    vla_pick u_pick (
        .want          (want),
        .full_free     (!unit_busy[UNIT_FULL]),
        .second_free   (!unit_busy[UNIT_SECOND]),
        .second_en     (second_en),
        .path_conflict (fpm_conflict),
        .pick          (pick)
    );

    assign unit_load[UNIT_FULL]   = (pick == PICK_FULL);
    assign unit_load[UNIT_SECOND] = (pick == PICK_SECOND);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        vla_res_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (unit_load[u]),
            .load_val (load_val),
            .busy     (unit_busy[u])
        );
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_READY: if (issue_req && pick == PICK_NONE) state_nx = ST_HOLD;
            ST_HOLD:  if (pick != PICK_NONE)              state_nx = ST_READY;
            default:  state_nx = ST_READY;
        endcase
    end

    // State register and captured vector length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_READY;
            pend_vl_q <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_READY && issue_req) pend_vl_q <= vec_len;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_full_q   <= 1'b0;
            grant_second_q <= 1'b0;
            hold_q         <= 1'b0;
        end else begin
            grant_full_q   <= unit_load[UNIT_FULL];
            grant_second_q <= unit_load[UNIT_SECOND];
            hold_q         <= (state_nx == ST_HOLD);
        end
    end

    assign grant_full   = grant_full_q;
    assign grant_second = grant_second_q;
    assign issue_hold   = hold_q;
    assign busy_full    = unit_busy[UNIT_FULL];
    assign busy_second  = unit_busy[UNIT_SECOND];
endmodule

// File: rtl/vla_issue_arb_chk.sv
`timescale 1ns/1ps
module vla_issue_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic issue_req,
    input logic second_en,
    input logic fpm_conflict,
    input logic grant_full,
    input logic grant_second,
    input logic issue_hold,
    input logic busy_full,
    input logic busy_second
);
    a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_full, grant_second}));

    a_r1_no_second_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        grant_second |-> $past(second_en));

    a_r5_conflict_blocks_second: assert property (@(posedge clk) disable iff (!rst_n)
        grant_second |-> !$past(fpm_conflict));

    a_r7_full_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        grant_full |-> !$past(busy_full));

    a_r7_second_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        grant_second |-> !$past(busy_second));

    a_r6_full_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        grant_full |-> busy_full);

    a_r6_second_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        grant_second |-> busy_second);

    a_r4_hold_excludes_grant: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hold |-> !(grant_full || grant_second));

    a_r9_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_full || grant_second) |=> !(grant_full || grant_second) || !$past(busy_second) || !$past(busy_full));

    a_r3_fallback_full: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && !issue_hold && !busy_full && busy_second) |=> grant_full);
endmodule

bind vla_issue_arb vla_issue_arb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_req    (issue_req),
    .second_en    (second_en),
    .fpm_conflict (fpm_conflict),
    .grant_full   (grant_full),
    .grant_second (grant_second),
    .issue_hold   (issue_hold),
    .busy_full    (busy_full),
    .busy_second  (busy_second)
);

// File: tb/vla_issue_arb_tb_top.sv
`timescale 1ns/1ps
module vla_issue_arb_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_req = 1'b0;
    logic [6:0] vec_len = 7'd1;
    logic       second_en = 1'b0;
    logic       fpm_conflict = 1'b0;
    logic       grant_full, grant_second, issue_hold, busy_full, busy_second;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        bit    gf;
        bit    gs;
        bit    hd;
        bit    bf;
        bit    bs;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // Bench reference state, from the requirements.
    int m_full = 0;
    int m_sec  = 0;
    bit m_pend = 0;
    int m_pvl  = 0;

    always #4 clk = ~clk;

    vla_issue_arb dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_req    (issue_req),
        .vec_len      (vec_len),
        .second_en    (second_en),
        .fpm_conflict (fpm_conflict),
        .grant_full   (grant_full),
        .grant_second (grant_second),
        .issue_hold   (issue_hold),
        .busy_full    (busy_full),
        .busy_second  (busy_second)
    );

    task automatic chk(string tag, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the predicted outputs.
    task automatic step(bit req, int vl, bit en, bit conf);
        exp_t e;
        bit   act, ok_s, gf, gs;
        int   evl;
        @(negedge clk);
        issue_req = req; vec_len = 7'(vl); second_en = en; fpm_conflict = conf;
        act  = m_pend || req;
        evl  = m_pend ? m_pvl : vl;
        ok_s = en && (m_sec == 0) && !conf;
        gf = 0; gs = 0;
        e.tag = "R6";
        if (act) begin
            if (ok_s) begin
                gs = 1;
                e.tag = m_pend ? ((m_full == 0) ? "R8 R9" : "R7 R9") : "R2 R9";
            end else if (m_full == 0) begin
                gf = 1;
                if (m_pend) e.tag = (m_sec == 0) ? "R8 R5 R9" : "R7 R9";
                else e.tag = !en ? "R1 R9" : (conf ? "R5 R9" : "R3 R9");
            end else begin
                e.tag = m_pend ? "R4 hold-ignore" : (!en ? "R1 R4" : (conf ? "R5 R4" : "R4"));
            end
        end
        m_full = gf ? evl + 2 : (m_full > 0 ? m_full - 1 : 0);
        m_sec  = gs ? evl + 2 : (m_sec  > 0 ? m_sec  - 1 : 0);
        if (gf || gs) m_pend = 0;
        else if (act && !m_pend) begin m_pend = 1; m_pvl = vl; end
        e.gf = gf; e.gs = gs; e.hd = m_pend;
        e.bf = (m_full != 0); e.bs = (m_sec != 0);
        exp_q.push_back(e);
    endtask

    task automatic idle(int n, bit en);
        for (int i = 0; i < n; i++) step(0, 1, en, 0);
    endtask

    // Monitor: pops and compares one expected item per cycle.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "grant_full",   grant_full,   e.gf);
                chk(e.tag, "grant_second", grant_second, e.gs);
                chk(e.tag, "issue_hold",   issue_hold,   e.hd);
                chk({e.tag, " R6"}, "busy_full",   busy_full,   e.bf);
                chk({e.tag, " R6"}, "busy_second", busy_second, e.bs);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk("R10", "grant_full",   grant_full,   0);
        chk("R10", "grant_second", grant_second, 0);
        chk("R10", "issue_hold",   issue_hold,   0);
        chk("R10", "busy_full",    busy_full,    0);
        chk("R10", "busy_second",  busy_second,  0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled secondary unit, full unit gets the instruction
        step(1, 4, 0, 0);
        idle(8, 0);
        // R2 then R3: secondary first, full as fallback
        step(1, 3, 1, 0);
        step(1, 5, 1, 0);
        // R4/R7: both busy, wait; requests during the wait carry vl=60 and are ignored
        step(1, 2, 1, 0);
        while (m_pend) step(1, 60, 1, 0);
        idle(12, 1);
        // R5: conflict sends to full; second request waits for full
        step(1, 6, 1, 1);
        step(1, 3, 1, 1);
        while (m_pend) step(0, 1, 1, 1);
        idle(12, 1);
        // R8: both free together while holding, secondary wins
        step(1, 4, 1, 0);
        step(1, 3, 1, 0);
        step(1, 2, 1, 0);
        while (m_pend) step(0, 1, 1, 0);
        idle(12, 1);
        // R8 with conflict at the tie: full wins
        step(1, 4, 1, 0);
        step(1, 3, 1, 0);
        step(1, 2, 1, 0);
        while (m_pend) step(0, 1, 1, 1);
        idle(12, 1);
        // R1 with full busy: wait although the secondary unit is idle
        step(1, 5, 0, 0);
        step(1, 5, 0, 0);
        while (m_pend) step(0, 1, 0, 0);
        idle(12, 0);
        // R6 boundaries: longest and shortest vectors
        step(1, 64, 1, 0);
        step(1, 1, 1, 0);
        idle(70, 1);
        // R7: back-to-back reuse the cycle busy drops
        step(1, 1, 0, 0);
        idle(2, 0);
        step(1, 1, 0, 0);
        idle(6, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule